// File: doc/BRIEF.md
# Codec Reset, Start-up and Power-down Sequencer

This block sits beside the control register bank of an audio codec and decides when that bank may be programmed. While the active-low reset/power-down pin is held low, every control register is returned to its default value. The one exception is the analog-output enable register, which keeps its contents so that a reset causes no audible pop. Once the pin is released, the block holds a busy flag high until the PLL has reported lock for a fixed run of consecutive master clock cycles. If lock is lost during that run, the run starts again from zero. Register writes that arrive while busy is high are dropped.

On the clock edge where reset is released, the serial-control pins are sampled as straps. If SCL and both address pins are low, the codec enters standalone mode. In that mode the register defaults are patched in two places: the internal master-clock enable is set, and the ADC clock master/slave choice follows the level seen on SDA. Three control registers each carry a power-down bit for their own section: clock, DAC and ADC. Setting one of these bits affects only that section's output.

Top module: `codec_init_seq`

## Requirements
- R1: On every rising clock edge where `rst_pin_n` is low, each register index i other than 3 is loaded with the default value i*16 (index 0 = 0x00, index 2 = 0x20, index 5 = 0x50). The value appears on `rd_data` for `rd_addr` = i from the next cycle.
- R2: Register index 3 is the analog-output register, with bit 0 driving `aout_en`. Neither reset nor strap capture alters it; only a register write changes it.
- R3: `busy` is high from the cycle after the first edge that samples reset low. It falls after INIT_CYC consecutive edges with `pll_locked` high that follow the release edge (the first edge with `rst_pin_n` high). With lock held throughout, `busy` is low after the (INIT_CYC+1)-th edge counted from and including the release edge.
- R4: An edge during initialisation where `pll_locked` is low restarts the lock count from zero.
- R5: A write (`wr_en` high) on an edge where `busy` is high, or on an edge where reset is asserted, changes no register.
- R6: A write on an edge where `busy` is low stores `wr_data` at `wr_addr`. `rd_data` shows the stored value from the next cycle.
- R7: Power-down bits sit at bit 0 of each section register: index 0 drives `pd_clk`, index 1 drives `pd_dac`, index 2 drives `pd_adc`. Writing one register leaves the other two outputs and all other registers unchanged.
- R8: On the release edge, `standalone` is loaded with 1 when `scl_pin`, `addr0_pin` and `addr1_pin` are all low, and with 0 otherwise. It is cleared by reset and holds its value between release edges.
- R9: When standalone is selected on the release edge, register 0 bit 1 (`mclk_int_en`) becomes 1 and register 2 bit 1 (`adc_clk_master`) takes the level of `sda_pin` (0 = slave, 1 = master). All other registers keep their defaults, so register 0 reads 0x02 and register 2 reads 0x20 or 0x22.
- R10: `dflt_load` is high in each cycle that follows an edge sampling reset low. It falls after the release edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_pin_n | input | 1 | Active-low reset/power-down pin, sampled synchronously |
| pll_locked | input | 1 | PLL lock indication |
| scl_pin | input | 1 | Serial clock pin level, used as a strap |
| sda_pin | input | 1 | Serial data pin level, used as a strap |
| addr0_pin | input | 1 | Address strap bit 0 |
| addr1_pin | input | 1 | Address strap bit 1 |
| wr_en | input | 1 | Register write request |
| wr_addr | input | AW | Register index to write |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Register index to read |
| rd_data | output | DW | Contents of the register at rd_addr |
| busy | output | 1 | Initialisation in progress; writes are dropped |
| dflt_load | output | 1 | Default load in progress |
| standalone | output | 1 | Standalone mode selected by the straps |
| mclk_int_en | output | 1 | Internal master-clock enable (register 0 bit 1) |
| adc_clk_master | output | 1 | ADC clocks master (1) or slave (0) (register 2 bit 1) |
| pd_clk | output | 1 | Clock section power-down |
| pd_dac | output | 1 | DAC section power-down |
| pd_adc | output | 1 | ADC section power-down |
| aout_en | output | 1 | Analog-output enable, kept through reset |

## Verification
The bench builds the block with INIT_CYC = 12, NREG = 8 and DW = 8. The short count makes it practical to observe the exact edge where busy falls, to drop lock partway through a count and watch the restart, and to cycle through several resets with different strap patterns. The eight-entry bank covers the three power-down registers, the preserved analog register and ordinary registers, so the effect of defaults and of dropped writes can be read back directly.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
    localparam int CLK_REG  = 0;
    localparam int DAC_REG  = 1;
    localparam int ADC_REG  = 2;
    localparam int ANA_REG  = 3;
    localparam int PD_BIT   = 0;
    localparam int MCLK_BIT = 1;
    localparam int ADCM_BIT = 1;
    localparam int AOUT_BIT = 0;
    localparam int DFLT_STEP = 16;
endpackage

// File: rtl/codec_init_ctl.sv
module codec_init_ctl #(
    parameter int INIT_CYC = 256
) (
    input  logic clk,
    input  logic rst_pin_n,
    input  logic pll_locked,
    output logic in_reset,
    output logic release_now,
    output logic busy
);
    localparam int CW = $clog2(INIT_CYC + 1);

    typedef struct packed {
        logic          in_rst;
        logic          busy;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_pin_n) begin
            st_d.in_rst = 1'b1;
            st_d.busy   = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.in_rst) begin
            st_d.in_rst = 1'b0;
            st_d.cnt    = '0;
        end else if (st_q.busy) begin
            if (!pll_locked) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == CW'(INIT_CYC - 1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign in_reset    = st_q.in_rst;
    assign release_now = rst_pin_n & st_q.in_rst;
    assign busy        = st_q.busy;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_pin_n)
        st_q.cnt < CW'(INIT_CYC)); // R3
    AST_UNLOCK_RESTART: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (st_q.busy && !st_q.in_rst && !pll_locked) |=> (st_q.busy && st_q.cnt == '0)); // R4
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $fell(st_q.busy) |-> ($past(st_q.cnt) == CW'(INIT_CYC - 1) && $past(pll_locked))); // R3
    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_pin_n)
        st_q.in_rst |-> st_q.busy); // R10
endmodule

// File: rtl/codec_strap_cap.sv
module codec_strap_cap (
    input  logic clk,
    input  logic rst_pin_n,
    input  logic capture,
    input  logic scl_pin,
    input  logic addr0_pin,
    input  logic addr1_pin,
    output logic sa_now,
    output logic standalone
);
    typedef struct packed {
        logic sa;
    } strap_t;

    strap_t st_d, st_q;

    assign sa_now = ~scl_pin & ~addr0_pin & ~addr1_pin;

    always_comb begin
        st_d = st_q;
        if (!rst_pin_n) begin
            st_d.sa = 1'b0;
        end else if (capture) begin
            st_d.sa = sa_now;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign standalone = st_q.sa;

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_pin_n)
        !capture |=> $stable(st_q.sa)); // R8
    AST_STRAP_TAKE: assert property (@(posedge clk) disable iff (!rst_pin_n)
        capture |=> (st_q.sa == $past(sa_now))); // R8
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
    import codec_seq_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 8,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_pin_n,
    input  logic          apply_strap,
    input  logic          sa_now,
    input  logic          sda_pin,
    input  logic          wr_allow,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          pd_clk,
    output logic          pd_dac,
    output logic          pd_adc,
    output logic          mclk_int_en,
    output logic          adc_clk_master,
    output logic          aout_en
);
    typedef logic [DW-1:0] word_t;

    typedef struct packed {
        word_t [NREG-1:0] r;
    } bank_t;

    bank_t bk_d, bk_q;
    word_t dflt_w [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_dflt
        assign dflt_w[g] = DW'(g * DFLT_STEP);
    end

    always_comb begin
        bk_d = bk_q;
        if (!rst_pin_n || apply_strap) begin
            for (int i = 0; i < NREG; i++) begin
                if (i != ANA_REG) bk_d.r[i] = dflt_w[i];
            end
            if (rst_pin_n && sa_now) begin
                bk_d.r[CLK_REG][MCLK_BIT] = 1'b1;
                bk_d.r[ADC_REG][ADCM_BIT] = sda_pin;
            end
        end else if (wr_allow && wr_en && (int'(wr_addr) < NREG)) begin
            bk_d.r[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        bk_q <= bk_d;
    end

    assign rd_data        = (int'(rd_addr) < NREG) ? bk_q.r[rd_addr] : '0;
    assign pd_clk         = bk_q.r[CLK_REG][PD_BIT];
    assign pd_dac         = bk_q.r[DAC_REG][PD_BIT];
    assign pd_adc         = bk_q.r[ADC_REG][PD_BIT];
    assign mclk_int_en    = bk_q.r[CLK_REG][MCLK_BIT];
    assign adc_clk_master = bk_q.r[ADC_REG][ADCM_BIT];
    assign aout_en        = bk_q.r[ANA_REG][AOUT_BIT];

    AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (!wr_allow && !apply_strap) |=> $stable(bk_q)); // R5
    AST_ANA_HELD: assert property (@(posedge clk) disable iff (!rst_pin_n)
        apply_strap |=> $stable(bk_q.r[ANA_REG])); // R2
    AST_SA_MCLK: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (apply_strap && sa_now) |=> bk_q.r[CLK_REG][MCLK_BIT]); // R9
endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq #(
    parameter int NREG     = 8,
    parameter int DW       = 8,
    parameter int INIT_CYC = 256,
    localparam int AW      = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_pin_n,
    input  logic          pll_locked,
    input  logic          scl_pin,
    input  logic          sda_pin,
    input  logic          addr0_pin,
    input  logic          addr1_pin,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          dflt_load,
    output logic          standalone,
    output logic          mclk_int_en,
    output logic          adc_clk_master,
    output logic          pd_clk,
    output logic          pd_dac,
    output logic          pd_adc,
    output logic          aout_en
);
    logic release_now;
    logic sa_now;
    logic busy_w;

    codec_init_ctl #(.INIT_CYC(INIT_CYC)) u_ctl (
        .clk         (clk),
        .rst_pin_n   (rst_pin_n),
        .pll_locked  (pll_locked),
        .in_reset    (dflt_load),
        .release_now (release_now),
        .busy        (busy_w)
    );

    codec_strap_cap u_strap (
        .clk        (clk),
        .rst_pin_n  (rst_pin_n),
        .capture    (release_now),
        .scl_pin    (scl_pin),
        .addr0_pin  (addr0_pin),
        .addr1_pin  (addr1_pin),
        .sa_now     (sa_now),
        .standalone (standalone)
    );

    codec_reg_bank #(.NREG(NREG), .DW(DW), .AW(AW)) u_bank (
        .clk            (clk),
        .rst_pin_n      (rst_pin_n),
        .apply_strap    (release_now),
        .sa_now         (sa_now),
        .sda_pin        (sda_pin),
        .wr_allow       (~busy_w),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .pd_clk         (pd_clk),
        .pd_dac         (pd_dac),
        .pd_adc         (pd_adc),
        .mclk_int_en    (mclk_int_en),
        .adc_clk_master (adc_clk_master),
        .aout_en        (aout_en)
    );

    assign busy = busy_w;
endmodule

// File: tb/sim_codec_init_seq.sv
`timescale 1ns/1ps
module sim_codec_init_seq;
    localparam int NREG = 8;
    localparam int DW   = 8;
    localparam int INIT = 12;
    localparam int AW   = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_pin_n = 1'b0, pll_locked = 1'b0;
    logic scl_pin = 1'b1, sda_pin = 1'b1, addr0_pin = 1'b0, addr1_pin = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic busy, dflt_load, standalone, mclk_int_en, adc_clk_master;
    logic pd_clk, pd_dac, pd_adc, aout_en;

    codec_init_seq #(.NREG(NREG), .DW(DW), .INIT_CYC(INIT)) u0 (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // behavioural reference
    int m_regs[NREG];
    bit m_valid = 0, m_inrst = 0, m_busy = 0, m_sa = 0, m_ana_known = 0;
    int m_cnt = 0;

    always @(posedge clk) begin
        if (!rst_pin_n) begin
            for (int i = 0; i < NREG; i++) if (i != 3) m_regs[i] = i * 16;
            m_inrst = 1; m_busy = 1; m_cnt = 0; m_sa = 0; m_valid = 1;
        end else if (m_inrst) begin
            for (int i = 0; i < NREG; i++) if (i != 3) m_regs[i] = i * 16;
            m_sa = (!scl_pin && !addr0_pin && !addr1_pin);
            if (m_sa) begin
                m_regs[0] = m_regs[0] | 2;
                m_regs[2] = 32 + (sda_pin ? 2 : 0);
            end
            m_inrst = 0; m_cnt = 0;
        end else if (m_busy) begin
            if (!pll_locked) m_cnt = 0;
            else begin
                m_cnt++;
                if (m_cnt == INIT) begin m_busy = 0; m_cnt = 0; end
            end
        end else if (wr_en) begin
            m_regs[wr_addr] = int'(wr_data);
            if (wr_addr == 3) m_ana_known = 1;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        if (!m_valid) return;
        chk(busy == m_busy, "R3 busy", busy, m_busy);
        chk(dflt_load == m_inrst, "R10 dflt_load", dflt_load, m_inrst);
        chk(standalone == m_sa, "R8 standalone", standalone, m_sa);
        chk(pd_clk == m_regs[0][0], "R7 pd_clk", pd_clk, m_regs[0][0]);
        chk(pd_dac == m_regs[1][0], "R7 pd_dac", pd_dac, m_regs[1][0]);
        chk(pd_adc == m_regs[2][0], "R7 pd_adc", pd_adc, m_regs[2][0]);
        chk(mclk_int_en == m_regs[0][1], "R9 mclk_int_en", mclk_int_en, m_regs[0][1]);
        chk(adc_clk_master == m_regs[2][1], "R9 adc_clk_master", adc_clk_master, m_regs[2][1]);
        if (rd_addr != 3 || m_ana_known)
            chk(int'(rd_data) == m_regs[rd_addr], "R6 rd_data", rd_data, m_regs[rd_addr]);
        if (m_ana_known)
            chk(aout_en == m_regs[3][0], "R2 aout_en", aout_en, m_regs[3][0]);
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        compare();
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200; i++) begin
            if (!busy) return;
            tick();
        end
        chk(0, "R3 busy never fell", busy, 0);
    endtask

    task automatic wr(int a, int d);
        wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
        tick();
        wr_en = 0;
    endtask

    task automatic rd_chk(int a, int exp, string tag);
        rd_addr = AW'(a);
        #1;
        chk(int'(rd_data) == exp, tag, rd_data, exp);
    endtask

    task automatic do_reset(bit scl, bit sda, bit a0, bit a1);
        rst_pin_n = 0; pll_locked = 0;
        scl_pin = scl; sda_pin = sda; addr0_pin = a0; addr1_pin = a1;
        repeat (3) tick();
        chk(busy == 1, "R3 busy in reset", busy, 1);
        chk(dflt_load == 1, "R10 dflt_load in reset", dflt_load, 1);
        rst_pin_n = 1; pll_locked = 1;
        tick();
        chk(dflt_load == 0, "R10 dflt_load after release", dflt_load, 0);
        scl_pin = 1; sda_pin = 1;
    endtask

    initial begin
        int n;
        repeat (3) tick();
        // first start: not standalone, lock arrives late and drops once
        scl_pin = 1;
        tick();
        chk(busy == 1, "R3 busy after reset", busy, 1);
        for (int i = 0; i < NREG; i++)
            if (i != 3) rd_chk(i, i * 16, "R1 default value");
        rst_pin_n = 1;
        tick();
        repeat (2) tick();
        pll_locked = 1;
        repeat (5) tick();
        wr(5, 8'hAB);                 // R5 discarded while busy
        pll_locked = 0;
        tick();                       // R4 restart
        pll_locked = 1;
        n = 0;
        while (busy && n < 100) begin tick(); n++; end
        chk(n == INIT, "R4 full recount after lock loss", n, INIT);
        rd_chk(5, 8'h50, "R5 write during busy dropped");
        chk(standalone == 0, "R8 strap not standalone", standalone, 0);

        // programming after init
        wr(3, 1);
        wr(1, 8'h11);
        wr(5, 8'hAB);
        rd_chk(5, 8'hAB, "R6 write accepted");
        chk(pd_dac == 1 && pd_clk == 0 && pd_adc == 0, "R7 only DAC powered down",
            {pd_clk, pd_dac, pd_adc}, 3'b010);
        rd_chk(2, 8'h20, "R7 neighbour unchanged");
        wr(0, 8'h01);
        chk(pd_clk == 1 && pd_dac == 1, "R7 clock power-down", pd_clk, 1);
        chk(aout_en == 1, "R2 analog enable set", aout_en, 1);

        // reset keeps analog register; standalone master via straps
        do_reset(0, 1, 0, 0);
        rd_chk(3, 1, "R2 analog register kept");
        chk(aout_en == 1, "R2 aout_en kept through reset", aout_en, 1);
        rd_chk(1, 8'h10, "R1 DAC reg back to default");
        chk(standalone == 1, "R8 standalone captured", standalone, 1);
        rd_chk(0, 8'h02, "R9 mclk forced");
        rd_chk(2, 8'h22, "R9 ADC master");
        n = 1;
        while (busy && n < 100) begin tick(); n++; end
        chk(n == INIT + 1, "R3 busy release edge count", n, INIT + 1);

        // standalone slave
        do_reset(0, 0, 0, 0);
        rd_chk(2, 8'h20, "R9 ADC slave");
        chk(mclk_int_en == 1, "R9 mclk enable", mclk_int_en, 1);
        wait_ready();

        // address strap high: not standalone
        do_reset(0, 1, 1, 0);
        chk(standalone == 0, "R8 addr strap blocks standalone", standalone, 0);
        rd_chk(0, 8'h00, "R9 no override outside standalone");
        wait_ready();
        wr(6, 8'h3C);
        rd_chk(6, 8'h3C, "R6 write after restart");
        repeat (3) tick();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            total++; bad++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule